// File: doc/BRIEF.md
# Viterbi Add-Compare-Select Butterfly

This block performs the add-compare-select step for one butterfly of a Viterbi decoder trellis. It takes the accumulated path metrics of two source states, `old0_i` and `old1_i`, together with the four branch metrics for the transitions that leave them. Each of the two destination states gets two candidate metrics. The block keeps the smaller candidate as the new path metric of that state. For each destination state it also outputs a decision bit, which goes to the survivor store used later by traceback.

The two candidates for a state are compared by subtracting one from the other at one bit wider than the metric width. The sign of that difference does two jobs. It drives the survivor multiplexer, and it is emitted as the decision bit, so the stored decision always matches the metric that was kept.

A normalization request subtracts one shared offset from both new metrics in the same result. This keeps metrics from running away. The parameter `PIPE` inserts a register stage between the adders and the compare. It also sets the result latency to one or two cycles. A valid flag travels along with the data.

Top module: `acs_butterfly`

## Requirements
- R1: Branch metric `bmXY_i` belongs to the transition from source X to destination Y. A candidate is `(oldX_i + bmXY_i) mod 2^MW`. The new metric of state Y is the smaller of its two candidates, and the inputs are treated as unsigned.
- R2: When the two candidates of a state are equal, the candidate from `old0_i` is kept and its decision bit is 0.
- R3: A decision bit reads 1 exactly when the survivor came from `old1_i`, and 0 when it came from `old0_i`.
- R4: The comparison is exact over the whole unsigned range. A candidate of 0x00000A beats one of 0xFFFFFF. A sum that passes 2^MW wraps, so 0xFFFFFF + 2 gives a candidate of 1.
- R5: When `norm_i` is high with a valid input, both new metrics equal `(survivor - norm_off_i) mod 2^MW`. The decision bits are unchanged by normalization.
- R6: With `PIPE`=0 the result and `valid_o` appear one clock edge after the valid input. With `PIPE`=1 they appear two edges after it. `valid_o` pulses once per accepted input, and inputs presented on consecutive cycles give results on consecutive cycles.
- R7: While `valid_i` is low, all data inputs are ignored and the metric and decision outputs hold their last values.
- R8: During reset `valid_o`, both metrics and both decision bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input set is valid this cycle |
| old0_i | input | MW (24) | Path metric of source state 0 |
| old1_i | input | MW (24) | Path metric of source state 1 |
| bm00_i | input | BW (8) | Branch metric, source 0 to destination 0 |
| bm10_i | input | BW (8) | Branch metric, source 1 to destination 0 |
| bm01_i | input | BW (8) | Branch metric, source 0 to destination 1 |
| bm11_i | input | BW (8) | Branch metric, source 1 to destination 1 |
| norm_i | input | 1 | Subtract `norm_off_i` from both new metrics |
| norm_off_i | input | MW (24) | Shared normalization offset |
| valid_o | output | 1 | New metrics and decisions updated |
| new0_o | output | MW (24) | New path metric of destination 0 |
| new1_o | output | MW (24) | New path metric of destination 1 |
| dec0_o | output | 1 | Decision for destination 0 (1 = from source 1) |
| dec1_o | output | 1 | Decision for destination 1 (1 = from source 1) |

## Verification
The bench drives one build without the pipeline stage and one with it, both from the same stimulus. The build with `PIPE`=0 has its result one edge after the valid input, and the bench samples it 1 ns after that edge. The build with `PIPE`=1 has its result one edge later, and the bench samples it 1 ns after the second edge. At that same second sample, the bench also confirms that the unpipelined build has already dropped `valid_o`. In the streaming test the input changes every cycle, and each sample is matched against the input set that the latency count says it belongs to.

// File: rtl/acs_pkg.sv
package acs_pkg;
  typedef enum logic {
    SRC_OLD0 = 1'b0,
    SRC_OLD1 = 1'b1
  } acs_src_e;

  localparam int unsigned N_ST = 2;
endpackage

// File: rtl/acs_add.sv
module acs_add #(
  parameter int unsigned MW = 24,
  parameter int unsigned BW = 8
) (
  input  logic [MW-1:0] old_i,
  input  logic [BW-1:0] bm_i,
  output logic [MW-1:0] sum_o
);
  localparam int unsigned PAD = MW - BW;

  // modulo 2^MW sum
  assign sum_o = old_i + {{PAD{1'b0}}, bm_i};
endmodule

// File: rtl/acs_cmp_sel.sv
module acs_cmp_sel
  import acs_pkg::*;
#(
  parameter int unsigned MW = 24
) (
  input  logic [MW-1:0] cand0_i,
  input  logic [MW-1:0] cand1_i,
  output logic [MW-1:0] pick_o,
  output acs_src_e      src_o
);
  localparam int unsigned DW = MW + 1;

  logic [DW-1:0] diff_w;
  logic          sgn_w;

  // extra bit keeps the sign exact for unsigned operands
  assign diff_w = {1'b0, cand1_i} - {1'b0, cand0_i};
  assign sgn_w  = diff_w[DW-1];
  assign src_o  = sgn_w ? SRC_OLD1 : SRC_OLD0;
  // cand0 + (cand1 - cand0) recovers cand1 from the same difference
  assign pick_o = cand0_i + (sgn_w ? diff_w[MW-1:0] : '0);
endmodule

// File: rtl/acs_norm.sv
module acs_norm #(
  parameter int unsigned MW = 24
) (
  input  logic [MW-1:0] metric_i,
  input  logic [MW-1:0] off_i,
  input  logic          en_i,
  output logic [MW-1:0] metric_o
);
  assign metric_o = en_i ? (metric_i - off_i) : metric_i;
endmodule

// File: rtl/acs_butterfly.sv
module acs_butterfly
  import acs_pkg::*;
#(
  parameter int unsigned MW   = 24,
  parameter int unsigned BW   = 8,
  parameter bit          PIPE = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [MW-1:0] old0_i,
  input  logic [MW-1:0] old1_i,
  input  logic [BW-1:0] bm00_i,
  input  logic [BW-1:0] bm10_i,
  input  logic [BW-1:0] bm01_i,
  input  logic [BW-1:0] bm11_i,
  input  logic          norm_i,
  input  logic [MW-1:0] norm_off_i,
  output logic          valid_o,
  output logic [MW-1:0] new0_o,
  output logic [MW-1:0] new1_o,
  output logic          dec0_o,
  output logic          dec1_o
);
  // [from source][to destination]
  logic [MW-1:0] old_w  [N_ST];
  logic [BW-1:0] bm_w   [N_ST][N_ST];
  // [destination][from source]
  logic [MW-1:0] cand_w [N_ST][N_ST];

  assign old_w[0]   = old0_i;
  assign old_w[1]   = old1_i;
  assign bm_w[0][0] = bm00_i;
  assign bm_w[1][0] = bm10_i;
  assign bm_w[0][1] = bm01_i;
  assign bm_w[1][1] = bm11_i;

  // add stage
  for (genvar s = 0; s < N_ST; s++) begin : g_dst
    for (genvar p = 0; p < N_ST; p++) begin : g_src
      acs_add #(.MW(MW), .BW(BW)) u_add (
        .old_i (old_w[p]),
        .bm_i  (bm_w[p][s]),
        .sum_o (cand_w[s][p])
      );
    end
  end

  // optional register between add and compare
  logic [MW-1:0] cand_s [N_ST][N_ST];
  logic          vld_s;
  logic          nrm_s;
  logic [MW-1:0] off_s;

  if (PIPE) begin : g_pipe
    logic [MW-1:0] cand_q [N_ST][N_ST];
    logic          vld_q;
    logic          nrm_q;
    logic [MW-1:0] off_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= 1'b0;
      end else begin
        vld_q <= valid_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int s = 0; s < N_ST; s++) begin
          for (int p = 0; p < N_ST; p++) begin
            cand_q[s][p] <= '0;
          end
        end
        nrm_q <= 1'b0;
        off_q <= '0;
      end else if (valid_i) begin
        cand_q <= cand_w;
        nrm_q  <= norm_i;
        off_q  <= norm_off_i;
      end
    end

    assign cand_s = cand_q;
    assign vld_s  = vld_q;
    assign nrm_s  = nrm_q;
    assign off_s  = off_q;
  end else begin : g_flow
    assign cand_s = cand_w;
    assign vld_s  = valid_i;
    assign nrm_s  = norm_i;
    assign off_s  = norm_off_i;
  end

  // compare, select, normalize
  logic [MW-1:0] pick_w [N_ST];
  logic [MW-1:0] nm_w   [N_ST];
  acs_src_e      src_w  [N_ST];
  logic [MW-1:0] met_q  [N_ST];
  logic          dec_q  [N_ST];
  logic          vld_q2;

  for (genvar s = 0; s < N_ST; s++) begin : g_cs
    acs_cmp_sel #(.MW(MW)) u_cs (
      .cand0_i (cand_s[s][0]),
      .cand1_i (cand_s[s][1]),
      .pick_o  (pick_w[s]),
      .src_o   (src_w[s])
    );

    acs_norm #(.MW(MW)) u_nm (
      .metric_i (pick_w[s]),
      .off_i    (off_s),
      .en_i     (nrm_s),
      .metric_o (nm_w[s])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        met_q[s] <= '0;
        dec_q[s] <= 1'b0;
      end else if (vld_s) begin
        met_q[s] <= nm_w[s];
        dec_q[s] <= (src_w[s] == SRC_OLD1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q2 <= 1'b0;
    end else begin
      vld_q2 <= vld_s;
    end
  end

  assign valid_o = vld_q2;
  assign new0_o  = met_q[0];
  assign new1_o  = met_q[1];
  assign dec0_o  = dec_q[0];
  assign dec1_o  = dec_q[1];
endmodule

// File: rtl/acs_butterfly_chk.sv
module acs_butterfly_chk #(
  parameter int unsigned MW   = 24,
  parameter int unsigned BW   = 8,
  parameter bit          PIPE = 1'b1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [MW-1:0] old0_i,
  input logic [MW-1:0] old1_i,
  input logic [BW-1:0] bm00_i,
  input logic [BW-1:0] bm10_i,
  input logic [BW-1:0] bm01_i,
  input logic [BW-1:0] bm11_i,
  input logic          norm_i,
  input logic [MW-1:0] norm_off_i,
  input logic          valid_o,
  input logic [MW-1:0] new0_o,
  input logic [MW-1:0] new1_o,
  input logic          dec0_o,
  input logic          dec1_o
);
  localparam int unsigned LAT = PIPE ? 2 : 1;
  localparam int unsigned PAD = MW - BW;

  logic [MW-1:0] c00_w, c10_w, c01_w, c11_w;
  assign c00_w = old0_i + {{PAD{1'b0}}, bm00_i};
  assign c10_w = old1_i + {{PAD{1'b0}}, bm10_i};
  assign c01_w = old0_i + {{PAD{1'b0}}, bm01_i};
  assign c11_w = old1_i + {{PAD{1'b0}}, bm11_i};

  logic          dv   [LAT];
  logic          dn   [LAT];
  logic [MW-1:0] doff [LAT];
  logic [MW-1:0] d00  [LAT];
  logic [MW-1:0] d10  [LAT];
  logic [MW-1:0] d01  [LAT];
  logic [MW-1:0] d11  [LAT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < LAT; k++) begin
        dv[k] <= 1'b0; dn[k] <= 1'b0; doff[k] <= '0;
        d00[k] <= '0; d10[k] <= '0; d01[k] <= '0; d11[k] <= '0;
      end
    end else begin
      dv[0] <= valid_i; dn[0] <= norm_i; doff[0] <= norm_off_i;
      d00[0] <= c00_w; d10[0] <= c10_w; d01[0] <= c01_w; d11[0] <= c11_w;
      for (int k = 1; k < LAT; k++) begin
        dv[k] <= dv[k-1]; dn[k] <= dn[k-1]; doff[k] <= doff[k-1];
        d00[k] <= d00[k-1]; d10[k] <= d10[k-1];
        d01[k] <= d01[k-1]; d11[k] <= d11[k-1];
      end
    end
  end

  logic [MW-1:0] sv0_w, sv1_w;
  assign sv0_w = dec0_o ? d10[LAT-1] : d00[LAT-1];
  assign sv1_w = dec1_o ? d11[LAT-1] : d01[LAT-1];

  // R6
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == dv[LAT-1]);

  // R1
  survivor_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !dn[LAT-1]) |-> (new0_o == sv0_w && new1_o == sv1_w));

  // R1
  min_metric_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !dn[LAT-1]) |->
      (new0_o <= d00[LAT-1] && new0_o <= d10[LAT-1] &&
       new1_o <= d01[LAT-1] && new1_o <= d11[LAT-1]));

  // R2
  tie_src0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && d00[LAT-1] == d10[LAT-1]) |-> !dec0_o);

  // R5
  norm_offset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && dn[LAT-1]) |->
      (new0_o == sv0_w - doff[LAT-1] && new1_o == sv1_w - doff[LAT-1]));

  // R7
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(new0_o) && $stable(new1_o) &&
                  $stable(dec0_o) && $stable(dec1_o)));
endmodule

bind acs_butterfly acs_butterfly_chk #(.MW(MW), .BW(BW), .PIPE(PIPE)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .old0_i     (old0_i),
  .old1_i     (old1_i),
  .bm00_i     (bm00_i),
  .bm10_i     (bm10_i),
  .bm01_i     (bm01_i),
  .bm11_i     (bm11_i),
  .norm_i     (norm_i),
  .norm_off_i (norm_off_i),
  .valid_o    (valid_o),
  .new0_o     (new0_o),
  .new1_o     (new1_o),
  .dec0_o     (dec0_o),
  .dec1_o     (dec1_o)
);

// File: tb/sim_acs_butterfly.sv
`timescale 1ns/1ps
module sim_acs_butterfly;
  localparam int unsigned MW = 24;
  localparam int unsigned BW = 8;

  typedef struct packed {
    logic [MW-1:0] o0;
    logic [MW-1:0] o1;
    logic [BW-1:0] b00;
    logic [BW-1:0] b10;
    logic [BW-1:0] b01;
    logic [BW-1:0] b11;
    logic          nrm;
    logic [MW-1:0] off;
  } vec_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid_i = 1'b0;
  logic [MW-1:0] old0 = '0, old1 = '0, off = '0;
  logic [BW-1:0] bm00 = '0, bm10 = '0, bm01 = '0, bm11 = '0;
  logic          nrm = 1'b0;

  logic          vo_p, vo_f;
  logic [MW-1:0] n0_p, n1_p, n0_f, n1_f;
  logic          d0_p, d1_p, d0_f, d1_f;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  acs_butterfly #(.MW(MW), .BW(BW), .PIPE(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i),
    .old0_i(old0), .old1_i(old1),
    .bm00_i(bm00), .bm10_i(bm10), .bm01_i(bm01), .bm11_i(bm11),
    .norm_i(nrm), .norm_off_i(off),
    .valid_o(vo_p), .new0_o(n0_p), .new1_o(n1_p), .dec0_o(d0_p), .dec1_o(d1_p)
  );

  acs_butterfly #(.MW(MW), .BW(BW), .PIPE(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i),
    .old0_i(old0), .old1_i(old1),
    .bm00_i(bm00), .bm10_i(bm10), .bm01_i(bm01), .bm11_i(bm11),
    .norm_i(nrm), .norm_off_i(off),
    .valid_o(vo_f), .new0_o(n0_f), .new1_o(n1_f), .dec0_o(d0_f), .dec1_o(d1_f)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // independent model of the requirements
  task automatic model(input vec_t v, output logic [MW-1:0] m0, output logic [MW-1:0] m1,
                       output logic e0, output logic e1);
    logic [MW-1:0] a0, a1, b0, b1;
    a0 = v.o0 + MW'(v.b00);
    a1 = v.o1 + MW'(v.b10);
    b0 = v.o0 + MW'(v.b01);
    b1 = v.o1 + MW'(v.b11);
    e0 = (a1 < a0);
    e1 = (b1 < b0);
    m0 = e0 ? a1 : a0;
    m1 = e1 ? b1 : b0;
    if (v.nrm) begin
      m0 = m0 - v.off;
      m1 = m1 - v.off;
    end
  endtask

  task automatic drive(input vec_t v, input logic vld);
    old0 = v.o0; old1 = v.o1;
    bm00 = v.b00; bm10 = v.b10; bm01 = v.b01; bm11 = v.b11;
    nrm = v.nrm; off = v.off;
    valid_i = vld;
  endtask

  task automatic cmp_out(string tag, logic pipe, input vec_t v);
    logic [MW-1:0] m0, m1;
    logic e0, e1;
    model(v, m0, m1, e0, e1);
    if (pipe) begin
      chk({tag, " u0 valid"}, 32'(vo_p), 32'd1);
      chk({tag, " u0 new0"}, 32'(n0_p), 32'(m0));
      chk({tag, " u0 new1"}, 32'(n1_p), 32'(m1));
      chk({tag, " u0 dec0"}, 32'(d0_p), 32'(e0));
      chk({tag, " u0 dec1"}, 32'(d1_p), 32'(e1));
    end else begin
      chk({tag, " u1 valid"}, 32'(vo_f), 32'd1);
      chk({tag, " u1 new0"}, 32'(n0_f), 32'(m0));
      chk({tag, " u1 new1"}, 32'(n1_f), 32'(m1));
      chk({tag, " u1 dec0"}, 32'(d0_f), 32'(e0));
      chk({tag, " u1 dec1"}, 32'(d1_f), 32'(e1));
    end
  endtask

  // one input set; u1 due after 1 edge, u0 after 2
  task automatic run_one(string tag, input vec_t v);
    @(negedge clk);
    drive(v, 1'b1);
    @(posedge clk); #1;
    valid_i = 1'b0;
    cmp_out({tag, " R6"}, 1'b0, v);
    chk({tag, " R6 u0 not yet"}, 32'(vo_p), 32'd0);
    @(posedge clk); #1;
    cmp_out({tag, " R6"}, 1'b1, v);
    chk({tag, " R6 u1 pulse once"}, 32'(vo_f), 32'd0);
  endtask

  function automatic vec_t mk(logic [MW-1:0] o0, logic [MW-1:0] o1,
                              logic [BW-1:0] b00, logic [BW-1:0] b10,
                              logic [BW-1:0] b01, logic [BW-1:0] b11,
                              logic n, logic [MW-1:0] f);
    vec_t v;
    v.o0 = o0; v.o1 = o1; v.b00 = b00; v.b10 = b10;
    v.b01 = b01; v.b11 = b11; v.nrm = n; v.off = f;
    return v;
  endfunction

  task automatic t_reset();
    #12;
    chk("R8 u0 valid", 32'(vo_p), 32'd0);
    chk("R8 u0 metrics", 32'(n0_p | n1_p), 32'd0);
    chk("R8 u0 decisions", 32'({d0_p, d1_p}), 32'd0);
    chk("R8 u1 valid", 32'(vo_f), 32'd0);
    chk("R8 u1 metrics", 32'(n0_f | n1_f), 32'd0);
    chk("R8 u1 decisions", 32'({d0_f, d1_f}), 32'd0);
  endtask

  task automatic t_basic();
    run_one("R1 R3 mixed", mk(24'd100, 24'd200, 8'd10, 8'd5, 8'd200, 8'd3, 1'b0, '0));
    run_one("R1 R3 both old1", mk(24'd5000, 24'd1000, 8'd1, 8'd2, 8'd3, 8'd4, 1'b0, '0));
  endtask

  task automatic t_tie();
    run_one("R2 tie", mk(24'd70, 24'd60, 8'd0, 8'd10, 8'd5, 8'd15, 1'b0, '0));
    chk("R2 u0 dec0 tie", 32'(d0_p), 32'd0);
    chk("R2 u0 dec1 tie", 32'(d1_p), 32'd0);
  endtask

  task automatic t_wrap();
    run_one("R4 wrap", mk(24'hFFFFFF, 24'h00000A, 8'd2, 8'd0, 8'd0, 8'd0, 1'b0, '0));
    chk("R4 u0 new0 wrapped sum", 32'(n0_p), 32'h1);
    chk("R4 u0 new1 full range", 32'(n1_p), 32'hA);
    chk("R4 u0 dec1", 32'(d1_p), 32'd1);
  endtask

  task automatic t_norm();
    run_one("R5 norm", mk(24'd1000, 24'd900, 8'd50, 8'd200, 8'd255, 8'd20, 1'b1, 24'd900));
    chk("R5 u0 new0", 32'(n0_p), 32'd150);
    chk("R5 u0 new1", 32'(n1_p), 32'd20);
    chk("R5 u0 decisions", 32'({d0_p, d1_p}), 32'b01);
  endtask

  task automatic t_hold();
    vec_t last;
    last = mk(24'd300, 24'd310, 8'd7, 8'd1, 8'd2, 8'd9, 1'b0, '0);
    run_one("R7 setup", last);
    @(negedge clk);
    drive(mk(24'd1, 24'd2, 8'd3, 8'd4, 8'd5, 8'd6, 1'b1, 24'd77), 1'b0);
    repeat (3) @(posedge clk);
    #1;
    begin
      logic [MW-1:0] m0, m1;
      logic e0, e1;
      model(last, m0, m1, e0, e1);
      chk("R7 u0 valid low", 32'(vo_p), 32'd0);
      chk("R7 u1 valid low", 32'(vo_f), 32'd0);
      chk("R7 u0 new0 held", 32'(n0_p), 32'(m0));
      chk("R7 u0 new1 held", 32'(n1_p), 32'(m1));
      chk("R7 u1 new0 held", 32'(n0_f), 32'(m0));
      chk("R7 u1 new1 held", 32'(n1_f), 32'(m1));
      chk("R7 u0 decisions held", 32'({d0_p, d1_p}), 32'({e0, e1}));
      chk("R7 u1 decisions held", 32'({d0_f, d1_f}), 32'({e0, e1}));
    end
  endtask

  task automatic t_stream();
    vec_t vs [3];
    vs[0] = mk(24'd40, 24'd41, 8'd9, 8'd1, 8'd0, 8'd30, 1'b0, '0);
    vs[1] = mk(24'd800, 24'd100, 8'd0, 8'd255, 8'd1, 8'd2, 1'b1, 24'd50);
    vs[2] = mk(24'hABCDEF, 24'hABCDEF, 8'd3, 8'd3, 8'd4, 8'd1, 1'b0, '0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (k < 3) drive(vs[k], 1'b1);
      else valid_i = 1'b0;
      @(posedge clk); #1;
      if (k < 3) cmp_out("R6 stream", 1'b0, vs[k]);
      if (k > 0) cmp_out("R6 stream", 1'b1, vs[k-1]);
    end
  endtask

  initial begin
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R8 u0 idle after reset", 32'(vo_p), 32'd0);
    t_basic();
    t_tie();
    t_wrap();
    t_norm();
    t_hold();
    t_stream();
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R6 act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule